// File: doc/BRIEF.md
# Dual-Source Boot Image Loader

After reset, this block fills a processor's internal program memory with its first 512 instructions. These include the reset vector and the other system vectors. When the image is complete, the block lets the core begin execution. The image can come from one of two places. The first is a byte-wide external flash, read upward from byte address 0xC000, where each group of three consecutive bytes forms one 24-bit instruction word. The second is a host port, through which a supervising controller hands over whole 24-bit words using a valid/ready handshake.

A source-select strap picks the source. It has a pull-up on the board, so it reads high unless driven, and high means flash. The block samples the strap once, on the first clock edge after reset is released, and ignores it from then on. The host-port path exists for cases where the flash is blank, for example so that a diagnostic or programming image can be loaded from the controller.

Every word is written to program memory through a registered write port, at word addresses 0 to 511 in ascending order. The clock cycle after the final write, the block raises a single-cycle `core_start` pulse. `boot_done` then stays high until the next reset.

Top module: `boot_loader`

## Requirements
- R1: On the first rising clock edge after `rst_n` goes high, `boot_src_sel` is sampled. A value of 1 selects the flash source and a value of 0 selects the host source.
- R2: In flash mode, each byte address from 0xC000 to 0xC5FF is read exactly once, in ascending order. A read is the cycle in which `flash_rd` is high and `flash_addr` holds the address.
- R3: Word n is packed most significant byte first: bits 23:16 come from 0xC000+3n, bits 15:8 from 0xC000+3n+1, and bits 7:0 from 0xC000+3n+2.
- R4: In host mode, a word is taken on each rising edge where `host_valid` and `host_ready` are both high. Words are written to program memory in the order they were taken.
- R5: Exactly 512 program-memory writes occur, one per cycle in which `pm_we` is high. Their `pm_addr` values are 0, 1, ..., 511 in that order.
- R6: `host_ready` never rises in flash mode, and `flash_rd` never rises in host mode.
- R7: Once 512 words have been taken, `host_ready` stays low, and any further words offered on the host port are neither taken nor written.
- R8: `core_start` is high for exactly one cycle, the cycle right after the write to address 511. From that cycle on, `boot_done` stays high and `pm_we` stays low until reset.
- R9: A change of `boot_src_sel` after it has been sampled has no effect on the source or on the data written.
- R10: While `rst_n` is low, `pm_we`, `core_start`, `boot_done`, `host_ready` and `flash_rd` are all 0.
- R11: The flash byte is captured `RD_LAT` cycles after its read cycle. With the default `RD_LAT` of 1, that is the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_src_sel | input | 1 | Source strap: 1 = flash, 0 = host port |
| flash_rd | output | 1 | Flash read strobe, registered |
| flash_addr | output | 16 | Flash byte address, registered |
| flash_data | input | 8 | Flash read data, valid `RD_LAT` cycles after the strobe |
| host_valid | input | 1 | Host word offered |
| host_word | input | 24 | Host word data |
| host_ready | output | 1 | Loader can take a host word |
| pm_we | output | 1 | Program-memory write enable |
| pm_addr | output | 9 | Program-memory word address |
| pm_wdata | output | 24 | Program-memory write data |
| core_start | output | 1 | One-cycle pulse that releases the core |
| boot_done | output | 1 | Image loaded; stays high until reset |

## Verification
In host mode, two events can land in the same cycle: the 512th word is taken while the controller keeps `host_valid` high with an extra word behind it. The bench keeps valid asserted continuously past the end of the image. It then checks that `host_ready` falls before a 513th word can be taken, and that neither the write count nor the write stream grows. A second overlap comes from toggling the strap on every cycle while word writes are in flight, in both modes. For this case, the reference model compares each write's address and data, and the timing of `core_start`, on every clock.

// File: rtl/boot_pkg.sv
package boot_pkg;

    typedef enum logic [1:0] {
        ST_SAMPLE,
        ST_FLASH,
        ST_HOST,
        ST_DONE
    } boot_st_e;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_REQ,
        FR_WAIT,
        FR_END
    } fetch_st_e;

endpackage

// File: rtl/boot_flash_reader.sv
module boot_flash_reader
    import boot_pkg::*;
#(
    parameter int WORDS   = 512,
    parameter int WORD_W  = 24,
    parameter int BYTE_W  = 8,
    parameter int FADDR_W = 16,
    parameter int BASE    = 'hC000,
    parameter int RD_LAT  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    output logic               flash_rd,
    output logic [FADDR_W-1:0] flash_addr,
    input  logic [BYTE_W-1:0]  flash_data,
    output logic               word_vld,
    output logic [WORD_W-1:0]  word_data
);
    localparam int BPW    = WORD_W / BYTE_W;
    localparam int TOTAL  = WORDS * BPW;
    localparam int BCNT_W = $clog2(TOTAL + 1);
    localparam int LAT_W  = $clog2(RD_LAT + 1);
    localparam int PH_W   = (BPW > 1) ? $clog2(BPW) : 1;

    typedef struct packed {
        fetch_st_e          st;
        logic [FADDR_W-1:0] addr;
        logic [BCNT_W-1:0]  bcnt;
        logic [LAT_W-1:0]   lat;
        logic [PH_W-1:0]    phase;
        logic [WORD_W-1:0]  pack;
        logic               vld;
    } fetch_t;

    fetch_t q, d;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        case (q.st)
            FR_IDLE: begin
                if (en) begin
                    d.st   = FR_REQ;
                    d.addr = FADDR_W'(BASE);
                end
            end
            FR_REQ: begin
                d.st  = FR_WAIT;
                d.lat = LAT_W'(1);
            end
            FR_WAIT: begin
                if (q.lat == LAT_W'(RD_LAT)) begin
                    d.pack = {q.pack[WORD_W-BYTE_W-1:0], flash_data};
                    d.bcnt = q.bcnt + 1'b1;
                    if (q.phase == PH_W'(BPW - 1)) begin
                        d.phase = '0;
                        d.vld   = 1'b1;
                    end else begin
                        d.phase = q.phase + 1'b1;
                    end
                    if (q.bcnt == BCNT_W'(TOTAL - 1)) begin
                        d.st = FR_END;
                    end else begin
                        d.st   = FR_REQ;
                        d.addr = q.addr + 1'b1;
                    end
                end else begin
                    d.lat = q.lat + 1'b1;
                end
            end
            default: d.st = FR_END;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: FR_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign flash_rd   = (q.st == FR_REQ);
    assign flash_addr = q.addr;
    assign word_vld   = q.vld;
    assign word_data  = q.pack;

    // R2: reads stay inside the image window
    a_r2_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
        flash_rd |-> (flash_addr >= FADDR_W'(BASE)) &&
                     (flash_addr < FADDR_W'(BASE + TOTAL)));

    // R11: at least one wait cycle separates two reads
    a_r11_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        flash_rd |=> !flash_rd);

endmodule

// File: rtl/boot_host_intake.sv
module boot_host_intake #(
    parameter int WORDS  = 512,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              host_valid,
    input  logic [WORD_W-1:0] host_word,
    output logic              host_ready,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_data
);
    localparam int CNT_W = $clog2(WORDS + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              rdy;
        logic              vld;
        logic [WORD_W-1:0] data;
    } intake_t;

    intake_t q, d;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (q.rdy && host_valid) begin
            d.vld  = 1'b1;
            d.data = host_word;
            d.cnt  = q.cnt + 1'b1;
        end
        d.rdy = en && (d.cnt < CNT_W'(WORDS));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign host_ready = q.rdy;
    assign word_vld   = q.vld;
    assign word_data  = q.data;

    // R4: a taken word is forwarded unchanged on the next cycle
    a_r4_take_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready) |=> (word_vld && word_data == $past(host_word)));

    // R7: no word is forwarded unless one was taken
    a_r7_no_spurious_word: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_valid && host_ready) |=> !word_vld);

endmodule

// File: rtl/boot_loader.sv
module boot_loader
    import boot_pkg::*;
#(
    parameter int WORDS   = 512,
    parameter int WORD_W  = 24,
    parameter int BYTE_W  = 8,
    parameter int FADDR_W = 16,
    parameter int BASE    = 'hC000,
    parameter int RD_LAT  = 1,
    localparam int PM_AW  = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boot_src_sel,
    output logic               flash_rd,
    output logic [FADDR_W-1:0] flash_addr,
    input  logic [BYTE_W-1:0]  flash_data,
    input  logic               host_valid,
    input  logic [WORD_W-1:0]  host_word,
    output logic               host_ready,
    output logic               pm_we,
    output logic [PM_AW-1:0]   pm_addr,
    output logic [WORD_W-1:0]  pm_wdata,
    output logic               core_start,
    output logic               boot_done
);
    typedef struct packed {
        boot_st_e          st;
        logic              mode_flash;
        logic [PM_AW-1:0]  wcnt;
        logic              we;
        logic [PM_AW-1:0]  waddr;
        logic [WORD_W-1:0] wdata;
        logic              start;
        logic              done;
    } top_t;

    top_t q, d;

    logic              f_vld, h_vld;
    logic [WORD_W-1:0] f_word, h_word;

    boot_flash_reader #(
        .WORDS(WORDS), .WORD_W(WORD_W), .BYTE_W(BYTE_W),
        .FADDR_W(FADDR_W), .BASE(BASE), .RD_LAT(RD_LAT)
    ) u_flash (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (q.st == ST_FLASH),
        .flash_rd   (flash_rd),
        .flash_addr (flash_addr),
        .flash_data (flash_data),
        .word_vld   (f_vld),
        .word_data  (f_word)
    );

    boot_host_intake #(
        .WORDS(WORDS), .WORD_W(WORD_W)
    ) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (q.st == ST_HOST),
        .host_valid (host_valid),
        .host_word  (host_word),
        .host_ready (host_ready),
        .word_vld   (h_vld),
        .word_data  (h_word)
    );

    always_comb begin
        d       = q;
        d.we    = 1'b0;
        d.start = 1'b0;
        case (q.st)
            ST_SAMPLE: begin
                d.mode_flash = boot_src_sel;
                d.st         = boot_src_sel ? ST_FLASH : ST_HOST;
            end
            ST_FLASH, ST_HOST: begin
                if (q.mode_flash ? f_vld : h_vld) begin
                    d.we    = 1'b1;
                    d.waddr = q.wcnt;
                    d.wdata = q.mode_flash ? f_word : h_word;
                    d.wcnt  = q.wcnt + 1'b1;
                end
                if (q.we && q.waddr == PM_AW'(WORDS - 1)) begin
                    d.st    = ST_DONE;
                    d.start = 1'b1;
                    d.done  = 1'b1;
                end
            end
            default: d.st = ST_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_SAMPLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign pm_we      = q.we;
    assign pm_addr    = q.waddr;
    assign pm_wdata   = q.wdata;
    assign core_start = q.start;
    assign boot_done  = q.done;

    // R6: each source is only active in its own mode
    a_r6_ready_only_host: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> !q.mode_flash);
    a_r6_read_only_flash: assert property (@(posedge clk) disable iff (!rst_n)
        flash_rd |-> q.mode_flash);

    // R9: the latched source never changes after sampling
    a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_SAMPLE) |=> $stable(q.mode_flash));

    // R8: single start pulse, sticky done, no writes after done
    a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> boot_done);
    a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |-> !pm_we);

endmodule

// File: tb/boot_loader_tb.sv
module boot_loader_tb;
    localparam int WORDS  = 512;
    localparam int BASE   = 'hC000;
    localparam int RD_LAT = 1;
    localparam int NBYTES = WORDS * 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        boot_src_sel;
    logic        flash_rd;
    logic [15:0] flash_addr;
    logic [7:0]  flash_data;
    logic        host_valid;
    logic [23:0] host_word;
    logic        host_ready;
    logic        pm_we;
    logic [8:0]  pm_addr;
    logic [23:0] pm_wdata;
    logic        core_start;
    logic        boot_done;

    always #5 clk = ~clk;

    boot_loader #(.RD_LAT(RD_LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .boot_src_sel(boot_src_sel),
        .flash_rd(flash_rd), .flash_addr(flash_addr), .flash_data(flash_data),
        .host_valid(host_valid), .host_word(host_word), .host_ready(host_ready),
        .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
        .core_start(core_start), .boot_done(boot_done)
    );

    // flash model: address registered on a read, data RD_LAT cycles later
    logic [7:0]  fmem [NBYTES];
    logic [15:0] apipe [RD_LAT];
    logic [15:0] ofs;
    always @(posedge clk) begin
        if (flash_rd) apipe[0] <= flash_addr;
        for (int i = 1; i < RD_LAT; i++) apipe[i] <= apipe[i-1];
    end
    assign ofs        = apipe[RD_LAT-1] - 16'(BASE);
    assign flash_data = (int'(ofs) < NBYTES) ? fmem[ofs] : 8'h00;

    logic [23:0] hw [WORDS+16];
    logic [23:0] expq [$];

    int checks = 0;
    int fails  = 0;
    bit mon_on = 0;
    bit cur_flash;
    int nwrites, nreads;
    bit prev_last;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // cycle-by-cycle reference comparison
    always @(negedge clk) begin
        if (mon_on) begin
            if (flash_rd) begin
                chk(cur_flash, "R6 read strobe in host mode", 1, 0);
                chk(flash_addr == 16'(BASE + nreads), "R2 read address order",
                    flash_addr, BASE + nreads);
                nreads++;
            end
            if (host_ready) chk(!cur_flash, "R6 ready in flash mode", 1, 0);
            if (pm_we) begin
                chk(!boot_done, "R8 write after done", 1, 0);
                chk(int'(pm_addr) == nwrites, "R5 write address", pm_addr, nwrites);
                if (expq.size() == 0) begin
                    chk(0, "R7 extra write", nwrites, WORDS);
                end else begin
                    logic [23:0] e;
                    e = expq.pop_front();
                    chk(pm_wdata == e, cur_flash ? "R3 R11 flash word" : "R4 host word",
                        pm_wdata, e);
                end
                nwrites++;
            end
            chk(core_start == prev_last, "R8 start pulse timing", core_start, prev_last);
            prev_last = pm_we && (pm_addr == 9'(WORDS - 1));
        end
    end

    task automatic run(input bit flash, input int seed, input bit gaps, input bit toggle);
        int taken;
        bit will;
        int after;
        int guard;
        mon_on     = 0;
        rst_n      = 0;
        boot_src_sel = flash;
        host_valid = 0;
        host_word  = '0;
        expq.delete();
        for (int i = 0; i < NBYTES; i++) fmem[i] = 8'((i * 37) + (seed * 11) + (i >> 3));
        for (int i = 0; i < WORDS + 16; i++) hw[i] = 24'((i * 'h10307) ^ (seed * 'h5A5A5));
        for (int n = 0; n < WORDS; n++)
            expq.push_back(flash ? {fmem[3*n], fmem[3*n+1], fmem[3*n+2]} : hw[n]);
        nwrites = 0; nreads = 0; prev_last = 0; cur_flash = flash;
        repeat (3) @(negedge clk);
        chk({pm_we, core_start, boot_done, host_ready, flash_rd} == 5'b0,
            "R10 outputs in reset", {pm_we, core_start, boot_done, host_ready, flash_rd}, 0);
        mon_on = 1;
        rst_n  = 1;
        @(negedge clk);
        if (toggle) boot_src_sel = !flash;
        taken = 0; will = 0; after = 0; guard = 0;
        while (after < 12 && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (toggle) boot_src_sel = ~boot_src_sel;
            if (will) taken++;
            if (!flash) begin
                host_valid = gaps ? (((taken * 7 + guard) % 3) != 0) : 1'b1;
                host_word  = hw[taken];
                will       = host_valid && host_ready;
            end
            if (boot_done) after++;
        end
        chk(boot_done, "R8 done held", boot_done, 1);
        chk(nwrites == WORDS, "R5 write count", nwrites, WORDS);
        chk(expq.size() == 0, "R5 all words written", expq.size(), 0);
        if (flash) begin
            chk(nreads == NBYTES, "R1 R2 flash byte count", nreads, NBYTES);
        end else begin
            chk(nreads == 0, "R1 R6 no flash reads", nreads, 0);
            chk(taken == WORDS, "R7 host words taken", taken, WORDS);
            chk(!host_ready, "R7 ready low after image", host_ready, 0);
        end
        if (toggle) chk(nwrites == WORDS, "R9 strap toggling ignored", nwrites, WORDS);
        host_valid = 0;
        mon_on = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        run(1'b1, 1, 1'b0, 1'b0);
        run(1'b0, 2, 1'b1, 1'b0);
        run(1'b1, 3, 1'b0, 1'b1);
        run(1'b0, 4, 1'b0, 1'b1);
        run(1'b0, 5, 1'b1, 1'b1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule